// File: doc/BRIEF.md
# Serial On-Screen Display Command Decoder

This block sits between a host controller and the character generator of an on-screen display. The host shifts 8-bit words into it over a three-wire port made of an active-low select, a shift clock and a data line. Words are grouped into commands. A head word selects what the following parameter words mean. The decoder keeps the display configuration fields that the raster and video logic read. When the host sends character data, the decoder emits write strobes carrying a line, a column, an attribute flag and a character code to an external character memory.

The serial pins are sampled by the system clock, so they must already be synchronous to `clk`. Each high and low phase of the shift clock must last at least two system clock periods. A host session begins by pulling the select low and ends by raising it again. Once a session has started streaming characters, every word in it is treated as character data, and the write position advances by itself after each character.

Top module: `osd_cmd_decoder`

## Requirements
- R1: While `ser_cs_n` is low, the decoder takes one bit on each system clock edge where `ser_sclk` is seen high after having been low. Bits arrive most significant first and eight bits form a word. While `ser_cs_n` is high the bit count is held at zero, so a partial word is thrown away.
- R2: A word with bit 7 = 1 is a head word. Its bits 6:4 select the command: 0 = write position, 1 = character stream, 2 = vertical setup, 3 = horizontal setup, 4 = display control, 5 = sync control. The selection is kept until the next head word, so any number of words with bit 7 = 0 may follow and each is read under that command. Commands 6 and 7, and their data words, change no output.
- R3: For the write-position command, bits 3:0 of the head word set the line and bits 4:0 of a data word set the column.
- R4: After a head word with command 1, every word up to the rise of `ser_cs_n` is character data, including words with bit 7 = 1. Each such word raises `mem_we` for exactly one cycle: the cycle after the edge that took its last bit. That cycle also shows the current line and column, `mem_attr` = word bit 7 and `mem_code` = word bits 5:0.
- R5: After each character write, the column advances by one. From column 23 it wraps to 0 and the line advances by one. From line 9 the line wraps to 0.
- R6: A rising edge on `ser_cs_n` releases the character-stream lock and makes the write-position command current again.
- R7: Vertical head word: bits 1:0 go to `vsize_a` and bits 3:2 to `vsize_b`. Its data words set `vstart` from bits 5:0. The horizontal command fills `hsize_a`, `hsize_b` and `hstart` with the same bit positions.
- R8: Display-control head word: bit 3 = `test_mode`, bit 2 = `burst_off`, bit 1 = `osc_stop`, bit 0 = software reset. Its data words carry bit 5 = `non_interlace`, bit 4 = `border_on`, bit 3 = `blink_slow`, bit 2 = `blink_on`, bit 1 = `reverse_on` and bit 0 = `display_on`.
- R9: Sync-control head word: bits 3:2 go to `bg_phase`, bit 1 to `bg_off` and bit 0 to `int_sync`. Its data words set `det_count` from bits 3:0.
- R10: A display-control head word with bit 0 = 1 clears every configuration field and the write position to zero, which turns the display off. All later words are then ignored until `ser_cs_n` rises.
- R11: When `rst_n` is low at a clock edge, every output is cleared to zero. This reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_sclk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data, MSB first |
| mem_we | output | 1 | One-cycle character write strobe |
| mem_line | output | 4 | Write line |
| mem_col | output | 5 | Write column |
| mem_attr | output | 1 | Character attribute flag |
| mem_code | output | 6 | Character code |
| vsize_a | output | 2 | Vertical size, first row |
| vsize_b | output | 2 | Vertical size, second row |
| vstart | output | 6 | Vertical start position |
| hsize_a | output | 2 | Horizontal size, first row |
| hsize_b | output | 2 | Horizontal size, second row |
| hstart | output | 6 | Horizontal start position |
| test_mode | output | 1 | Test mode flag |
| burst_off | output | 1 | Colour burst disable |
| osc_stop | output | 1 | Oscillator stop request |
| non_interlace | output | 1 | Non-interlaced field select |
| border_on | output | 1 | Character border enable |
| blink_slow | output | 1 | Long blink period select |
| blink_on | output | 1 | Blink enable |
| reverse_on | output | 1 | Reverse video enable |
| display_on | output | 1 | Character display enable |
| bg_phase | output | 2 | Background colour phase |
| bg_off | output | 1 | Background colour disable |
| int_sync | output | 1 | Internal sync select |
| det_count | output | 4 | Sync detection count code |

## Verification
The decoder is driven with several kinds of sessions, and each kind separates a particular fault:
- A position session followed by a character session shows whether the line and column fields land in the right bits.
- Streams that cross column 23 and line 9 expose faulty wrap logic.
- A character stream carrying a word with bit 7 set tells the lock apart from head-word decoding.
- A data word sent straight after the select rises shows whether the write-position command really became current.
- Several data words under one command check that the command is retained.
- Reserved commands check that they change nothing.
- A partial word followed by a full word catches a bit counter that is not cleared.
- A software reset followed by more words in the same session shows that later words are ignored, and the next session shows that the hold is released.

// File: rtl/osd_cmd_pkg.sv
// Shared command codes, field widths and the configuration bundle
// for the serial on-screen display command decoder.
package osd_cmd_pkg;

    localparam int POS_W  = 6;
    localparam int SIZE_W = 2;
    localparam int DET_W  = 4;
    localparam int PH_W   = 2;

    typedef enum logic [2:0] {
        CMD_ADDR = 3'd0,
        CMD_CHAR = 3'd1,
        CMD_VERT = 3'd2,
        CMD_HORZ = 3'd3,
        CMD_DISP = 3'd4,
        CMD_SYNC = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } osd_cmd_e;

    typedef struct packed {
        logic [SIZE_W-1:0] vsize_a;
        logic [SIZE_W-1:0] vsize_b;
        logic [POS_W-1:0]  vstart;
        logic [SIZE_W-1:0] hsize_a;
        logic [SIZE_W-1:0] hsize_b;
        logic [POS_W-1:0]  hstart;
        logic              test_mode;
        logic              burst_off;
        logic              osc_stop;
        logic              non_interlace;
        logic              border_on;
        logic              blink_slow;
        logic              blink_on;
        logic              reverse_on;
        logic              display_on;
        logic [PH_W-1:0]   bg_phase;
        logic              bg_off;
        logic              int_sync;
        logic [DET_W-1:0]  det_count;
    } osd_cfg_t;

endpackage

// File: rtl/osd_serial_rx.sv
// Serial word receiver.
// Samples the select, shift clock and data pins with the system clock,
// detects shift clock rising edges while select is low and assembles
// MSB-first words. word_done and word are combinational views valid on
// the edge that takes the final bit. Assumes the pins are synchronous to
// clk and each shift clock phase lasts at least two clk periods.
module osd_serial_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              word_done,
    output logic [WORD_W-1:0] word,
    output logic              cs_rise
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic              sclk_d;
    logic              cs_d;
    logic [WORD_W-2:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              bit_take;

    assign bit_take  = sclk & ~sclk_d & ~cs_n;
    assign word_done = bit_take && (cnt_q == LAST_BIT);
    assign word      = {sh_q, din};
    assign cs_rise   = cs_n & ~cs_d;

    // Keep one cycle of pin history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
        end
    end

    // Shift in one bit per shift clock rise; count bits within the word.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (bit_take) begin
            sh_q  <= {sh_q[WORD_W-3:0], din};
            cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
        end
    end

    // R1: a deselected port always restarts at bit zero
    a_r1_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cnt_q == '0));

    // R1: a word can only complete while the port is selected
    a_r1_word_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> !cs_n);

endmodule

// File: rtl/osd_write_port.sv
// Character write pointer and memory write port.
// Holds the line/column pointer, loads it on request, issues one
// registered write strobe per character and advances the pointer with
// column and line wrap. Assumes wr, clear and the set requests never
// coincide.
module osd_write_port #(
    parameter int NUM_LINES = 10,
    parameter int NUM_COLS  = 24,
    parameter int LINE_W    = 4,
    parameter int COL_W     = 5,
    parameter int CODE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_line,
    input  logic [LINE_W-1:0] line_in,
    input  logic              set_col,
    input  logic [COL_W-1:0]  col_in,
    input  logic              wr,
    input  logic              wr_attr,
    input  logic [CODE_W-1:0] wr_code,
    output logic              mem_we,
    output logic [LINE_W-1:0] mem_line,
    output logic [COL_W-1:0]  mem_col,
    output logic              mem_attr,
    output logic [CODE_W-1:0] mem_code
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(NUM_LINES - 1);
    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);

    logic [LINE_W-1:0] line_q;
    logic [COL_W-1:0]  col_q;

    // Load, clear or auto-advance the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            line_q <= '0;
            col_q  <= '0;
        end else if (wr) begin
            if (col_q >= COL_LAST) begin
                col_q  <= '0;
                line_q <= (line_q >= LINE_LAST) ? '0 : line_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end else begin
            if (set_line) line_q <= line_in;
            if (set_col)  col_q  <= col_in;
        end
    end

    // Register the write strobe together with its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we   <= 1'b0;
            mem_line <= '0;
            mem_col  <= '0;
            mem_attr <= 1'b0;
            mem_code <= '0;
        end else begin
            mem_we <= wr;
            if (wr) begin
                mem_line <= line_q;
                mem_col  <= col_q;
                mem_attr <= wr_attr;
                mem_code <= wr_code;
            end
        end
    end

    // R4: each character gives a single-cycle strobe
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R5: a write from the last column lands the pointer on column zero
    a_r5_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && col_q == COL_LAST) |=> (col_q == '0));

    // R5: a write that is not at the last column keeps the line
    a_r5_line_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && col_q < COL_LAST) |=> $stable(line_q));

endmodule

// File: rtl/osd_cfg_regs.sv
// Command decoder and configuration register file.
// Tracks the current command, the character-stream lock and the
// software-reset hold; routes each received word either to the write
// port or to the configuration fields. Assumes word_done and cs_rise
// never coincide (a word needs the port selected).
module osd_cfg_regs
    import osd_cmd_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int LINE_W = 4,
    parameter int COL_W  = 5,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word,
    input  logic              cs_rise,
    output osd_cfg_t          cfg,
    output logic              clear,
    output logic              set_line,
    output logic [LINE_W-1:0] line_in,
    output logic              set_col,
    output logic [COL_W-1:0]  col_in,
    output logic              wr,
    output logic              wr_attr,
    output logic [CODE_W-1:0] wr_code
);
    localparam int HEAD_BIT = WORD_W - 1;

    osd_cmd_e cmd_q;
    logic     lock_q;
    logic     hold_q;
    logic     accept;
    logic     is_head;
    osd_cmd_e head_id;

    assign accept  = word_done && !hold_q;
    assign is_head = word[HEAD_BIT];
    assign head_id = osd_cmd_e'(word[HEAD_BIT-1 -: 3]);
    assign line_in = word[LINE_W-1:0];
    assign col_in  = word[COL_W-1:0];
    assign wr_attr = word[HEAD_BIT];
    assign wr_code = word[CODE_W-1:0];

    // Route the accepted word to a write, a pointer load or a reset.
    always_comb begin
        wr       = 1'b0;
        set_line = 1'b0;
        set_col  = 1'b0;
        clear    = 1'b0;
        if (accept) begin
            if (lock_q) begin
                wr = 1'b1;
            end else if (is_head) begin
                set_line = (head_id == CMD_ADDR);
                clear    = (head_id == CMD_DISP) && word[0];
            end else begin
                set_col = (cmd_q == CMD_ADDR);
            end
        end
    end

    // Track the current command, the stream lock and the reset hold.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_rise) begin
            cmd_q  <= CMD_ADDR;
            lock_q <= 1'b0;
            hold_q <= 1'b0;
        end else if (clear) begin
            cmd_q  <= CMD_ADDR;
            lock_q <= 1'b0;
            hold_q <= 1'b1;
        end else if (accept && !lock_q && is_head) begin
            cmd_q  <= head_id;
            lock_q <= (head_id == CMD_CHAR);
        end
    end

    // Load configuration fields from head words and data words.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cfg <= '0;
        end else if (accept && !lock_q) begin
            if (is_head) begin
                case (head_id)
                    CMD_VERT: begin
                        cfg.vsize_b <= word[3:2];
                        cfg.vsize_a <= word[1:0];
                    end
                    CMD_HORZ: begin
                        cfg.hsize_b <= word[3:2];
                        cfg.hsize_a <= word[1:0];
                    end
                    CMD_DISP: begin
                        cfg.test_mode <= word[3];
                        cfg.burst_off <= word[2];
                        cfg.osc_stop  <= word[1];
                    end
                    CMD_SYNC: begin
                        cfg.bg_phase <= word[3:2];
                        cfg.bg_off   <= word[1];
                        cfg.int_sync <= word[0];
                    end
                    default: ;
                endcase
            end else begin
                case (cmd_q)
                    CMD_VERT: cfg.vstart <= word[POS_W-1:0];
                    CMD_HORZ: cfg.hstart <= word[POS_W-1:0];
                    CMD_DISP: {cfg.non_interlace, cfg.border_on, cfg.blink_slow,
                               cfg.blink_on, cfg.reverse_on, cfg.display_on} <= word[5:0];
                    CMD_SYNC: cfg.det_count <= word[DET_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R6: a select rise always returns to the write-position command unlocked
    a_r6_cs_return: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (cmd_q == CMD_ADDR && !lock_q));

    // R4: the stream lock persists until the select rises
    a_r4_lock_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !cs_rise) |=> lock_q);

    // R10: during the reset hold the display stays dark and nothing is written
    a_r10_hold_dark: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (!cfg.display_on && !wr));

    // R2: routing outputs are mutually exclusive
    a_r2_route_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr, set_line, set_col, clear}));

endmodule

// File: rtl/osd_cmd_decoder.sv
// Top of the serial on-screen display command decoder.
// Connects the serial receiver, the command/configuration decoder and
// the character write port, and flattens the configuration bundle onto
// plain output ports. Assumes serial pins synchronous to clk.
module osd_cmd_decoder
    import osd_cmd_pkg::*;
#(
    parameter int NUM_LINES = 10,
    parameter int NUM_COLS  = 24,
    parameter int LINE_W    = 4,
    parameter int COL_W     = 5,
    parameter int CODE_W    = 6,
    parameter int WORD_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs_n,
    input  logic              ser_sclk,
    input  logic              ser_din,
    output logic              mem_we,
    output logic [LINE_W-1:0] mem_line,
    output logic [COL_W-1:0]  mem_col,
    output logic              mem_attr,
    output logic [CODE_W-1:0] mem_code,
    output logic [1:0]        vsize_a,
    output logic [1:0]        vsize_b,
    output logic [5:0]        vstart,
    output logic [1:0]        hsize_a,
    output logic [1:0]        hsize_b,
    output logic [5:0]        hstart,
    output logic              test_mode,
    output logic              burst_off,
    output logic              osc_stop,
    output logic              non_interlace,
    output logic              border_on,
    output logic              blink_slow,
    output logic              blink_on,
    output logic              reverse_on,
    output logic              display_on,
    output logic [1:0]        bg_phase,
    output logic              bg_off,
    output logic              int_sync,
    output logic [3:0]        det_count
);
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic              cs_rise;
    osd_cfg_t          cfg;
    logic              clear;
    logic              set_line;
    logic [LINE_W-1:0] line_in;
    logic              set_col;
    logic [COL_W-1:0]  col_in;
    logic              wr;
    logic              wr_attr;
    logic [CODE_W-1:0] wr_code;

    osd_serial_rx #(.WORD_W(WORD_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (ser_cs_n),
        .sclk      (ser_sclk),
        .din       (ser_din),
        .word_done (word_done),
        .word      (word),
        .cs_rise   (cs_rise)
    );

    osd_cfg_regs #(
        .WORD_W (WORD_W),
        .LINE_W (LINE_W),
        .COL_W  (COL_W),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .cs_rise   (cs_rise),
        .cfg       (cfg),
        .clear     (clear),
        .set_line  (set_line),
        .line_in   (line_in),
        .set_col   (set_col),
        .col_in    (col_in),
        .wr        (wr),
        .wr_attr   (wr_attr),
        .wr_code   (wr_code)
    );

    osd_write_port #(
        .NUM_LINES (NUM_LINES),
        .NUM_COLS  (NUM_COLS),
        .LINE_W    (LINE_W),
        .COL_W     (COL_W),
        .CODE_W    (CODE_W)
    ) u_wp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .set_line (set_line),
        .line_in  (line_in),
        .set_col  (set_col),
        .col_in   (col_in),
        .wr       (wr),
        .wr_attr  (wr_attr),
        .wr_code  (wr_code),
        .mem_we   (mem_we),
        .mem_line (mem_line),
        .mem_col  (mem_col),
        .mem_attr (mem_attr),
        .mem_code (mem_code)
    );

    assign vsize_a       = cfg.vsize_a;
    assign vsize_b       = cfg.vsize_b;
    assign vstart        = cfg.vstart;
    assign hsize_a       = cfg.hsize_a;
    assign hsize_b       = cfg.hsize_b;
    assign hstart        = cfg.hstart;
    assign test_mode     = cfg.test_mode;
    assign burst_off     = cfg.burst_off;
    assign osc_stop      = cfg.osc_stop;
    assign non_interlace = cfg.non_interlace;
    assign border_on     = cfg.border_on;
    assign blink_slow    = cfg.blink_slow;
    assign blink_on      = cfg.blink_on;
    assign reverse_on    = cfg.reverse_on;
    assign display_on    = cfg.display_on;
    assign bg_phase      = cfg.bg_phase;
    assign bg_off        = cfg.bg_off;
    assign int_sync      = cfg.int_sync;
    assign det_count     = cfg.det_count;

    // R11: the cycle after a reset edge shows no strobe and a dark display
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !display_on && vstart == '0));

endmodule

// File: tb/osd_cmd_decoder_test.sv
`timescale 1ns/1ps
module osd_cmd_decoder_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs_n = 1'b1;
    logic ser_sclk = 1'b1;
    logic ser_din = 1'b0;

    logic       mem_we;
    logic [3:0] mem_line;
    logic [4:0] mem_col;
    logic       mem_attr;
    logic [5:0] mem_code;
    logic [1:0] vsize_a, vsize_b, hsize_a, hsize_b, bg_phase;
    logic [5:0] vstart, hstart;
    logic       test_mode, burst_off, osc_stop, non_interlace, border_on;
    logic       blink_slow, blink_on, reverse_on, display_on, bg_off, int_sync;
    logic [3:0] det_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    osd_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_sclk(ser_sclk), .ser_din(ser_din),
        .mem_we(mem_we), .mem_line(mem_line), .mem_col(mem_col), .mem_attr(mem_attr),
        .mem_code(mem_code), .vsize_a(vsize_a), .vsize_b(vsize_b), .vstart(vstart),
        .hsize_a(hsize_a), .hsize_b(hsize_b), .hstart(hstart), .test_mode(test_mode),
        .burst_off(burst_off), .osc_stop(osc_stop), .non_interlace(non_interlace),
        .border_on(border_on), .blink_slow(blink_slow), .blink_on(blink_on),
        .reverse_on(reverse_on), .display_on(display_on), .bg_phase(bg_phase),
        .bg_off(bg_off), .int_sync(int_sync), .det_count(det_count)
    );

    // ---------------- behavioural reference model ----------------
    int m_line, m_col, m_cmd, m_cnt, m_sh;
    bit m_lock, m_hold, m_sclk_d, m_cs_d, m_started;
    int m_va, m_vb, m_vs, m_ha, m_hb, m_hs, m_dhead, m_ddata, m_ph, m_bgoff, m_int, m_det;
    bit m_we; int m_ml, m_mc, m_ma, m_mcode;

    task automatic m_clear_cfg();
        m_va = 0; m_vb = 0; m_vs = 0; m_ha = 0; m_hb = 0; m_hs = 0;
        m_dhead = 0; m_ddata = 0; m_ph = 0; m_bgoff = 0; m_int = 0; m_det = 0;
        m_line = 0; m_col = 0;
    endtask

    task automatic m_word(input int w);
        int id;
        if (m_hold) return;
        if (m_lock) begin
            m_we = 1; m_ml = m_line; m_mc = m_col; m_ma = (w >> 7) & 1; m_mcode = w & 63;
            if (m_col >= 23) begin
                m_col = 0;
                m_line = (m_line >= 9) ? 0 : m_line + 1;
            end else m_col = m_col + 1;
        end else if (w & 128) begin
            id = (w >> 4) & 7;
            m_cmd = id; m_lock = (id == 1);
            case (id)
                0: m_line = w & 15;
                2: begin m_vb = (w >> 2) & 3; m_va = w & 3; end
                3: begin m_hb = (w >> 2) & 3; m_ha = w & 3; end
                4: if (w & 1) begin m_clear_cfg(); m_hold = 1; m_cmd = 0; end
                   else m_dhead = (w >> 1) & 7;
                5: begin m_ph = (w >> 2) & 3; m_bgoff = (w >> 1) & 1; m_int = w & 1; end
                default: ;
            endcase
        end else begin
            case (m_cmd)
                0: m_col = w & 31;
                2: m_vs = w & 63;
                3: m_hs = w & 63;
                4: m_ddata = w & 63;
                5: m_det = w & 15;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        m_we = 0;
        if (!rst_n) begin
            m_clear_cfg();
            m_cmd = 0; m_lock = 0; m_hold = 0; m_cnt = 0; m_sh = 0;
            m_sclk_d = 0; m_cs_d = 1; m_ml = 0; m_mc = 0; m_ma = 0; m_mcode = 0;
            m_started = 1;
        end else begin
            if (ser_cs_n) begin
                m_cnt = 0; m_sh = 0;
                if (!m_cs_d) begin m_cmd = 0; m_lock = 0; m_hold = 0; end
            end else if (ser_sclk && !m_sclk_d) begin
                m_sh = ((m_sh << 1) | ser_din) & 255;
                m_cnt = m_cnt + 1;
                if (m_cnt == 8) begin m_cnt = 0; m_word(m_sh); end
            end
            m_sclk_d = ser_sclk; m_cs_d = ser_cs_n;
        end
    end

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (m_started && !done) begin
            cmp({31'd0, mem_we}, {31'd0, m_we}, "R4 mem_we");
            cmp({mem_line, mem_col, mem_attr, mem_code}, 32'((m_ml << 12) | (m_mc << 7) | (m_ma << 6) | m_mcode), "R5 write port");
            cmp({vsize_a, vsize_b, vstart, hsize_a, hsize_b, hstart},
                32'((m_va << 18) | (m_vb << 16) | (m_vs << 10) | (m_ha << 8) | (m_hb << 6) | m_hs), "R7 size/position");
            cmp({test_mode, burst_off, osc_stop, non_interlace, border_on, blink_slow, blink_on, reverse_on, display_on},
                32'((m_dhead << 6) | m_ddata), "R8 display control");
            cmp({bg_phase, bg_off, int_sync, det_count}, 32'((m_ph << 6) | (m_bgoff << 5) | (m_int << 4) | m_det), "R9 sync control");
        end
    end

    // Record every write strobe for directed checks.
    logic [15:0] wq[$];
    always @(negedge clk) if (mem_we === 1'b1) wq.push_back({mem_line, mem_col, mem_attr, mem_code});

    task automatic expect_write(input int line, input int col, input int attr, input int code, input string tag);
        logic [15:0] got;
        checks++;
        if (wq.size() == 0) begin
            fails++;
            $display("FAIL %s actual=none expected=%0d/%0d/%0d/%h", tag, line, col, attr, code);
        end else begin
            got = wq.pop_front();
            if (got !== 16'((line << 12) | (col << 7) | (attr << 6) | code)) begin
                fails++;
                $display("FAIL %s actual=%0d/%0d/%0d/%h expected=%0d/%0d/%0d/%h", tag,
                         got[15:12], got[11:7], got[6], got[5:0], line, col, attr, code);
            end
        end
    endtask

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input int val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_sclk = 1'b0; ser_din = (val >> i) & 1;
            tick(2);
            ser_sclk = 1'b1;
            tick(1);
        end
    endtask

    task automatic sel();   @(negedge clk); ser_cs_n = 1'b0; tick(2); endtask
    task automatic desel(); @(negedge clk); ser_cs_n = 1'b1; tick(3); endtask
    task automatic byte_out(input int b); send_bits(b, 8); endtask

    initial begin
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        tick(2);
        // R11: reset state
        cmp({mem_we, vsize_a, vstart, hstart, display_on, det_count}, 32'd0, "R11 reset state");

        // R3 / R4: set position line 3 col 5, then stream two characters
        sel(); byte_out(8'h83); byte_out(8'h05); desel();
        sel(); byte_out(8'h90); byte_out(8'h41); byte_out(8'hBF); desel();
        expect_write(3, 5, 0, 6'h01, "R3 first write position");
        expect_write(3, 6, 1, 6'h3F, "R4 attribute and code");

        // R5: column wrap and line advance
        sel(); byte_out(8'h82); byte_out(8'h16); desel();
        sel(); byte_out(8'h90); byte_out(8'h01); byte_out(8'h02); byte_out(8'h03); desel();
        expect_write(2, 22, 0, 6'h01, "R5 col 22");
        expect_write(2, 23, 0, 6'h02, "R5 col 23");
        expect_write(3, 0, 0, 6'h03, "R5 column wrap");
        sel(); byte_out(8'h89); byte_out(8'h17); desel();
        sel(); byte_out(8'h90); byte_out(8'h04); byte_out(8'h05); desel();
        expect_write(9, 23, 0, 6'h04, "R5 last cell");
        expect_write(0, 0, 0, 6'h05, "R5 line wrap");

        // R4: a head-looking word inside a stream is character data
        sel(); byte_out(8'h90); byte_out(8'hA5); desel();
        expect_write(0, 1, 1, 6'h25, "R4 locked word");
        cmp({vsize_a, vsize_b}, 32'd0, "R4 lock keeps vertical size");

        // R6: after select rise a bare data word is a column
        sel(); byte_out(8'h86); desel();
        sel(); byte_out(8'h04); byte_out(8'h90); byte_out(8'h11); desel();
        expect_write(6, 4, 0, 6'h11, "R6 return to position command");

        // R7 and R2 retention
        sel(); byte_out(8'hA6); byte_out(8'h2A); byte_out(8'h15); byte_out(8'hB9); byte_out(8'h3F); desel();
        cmp({vsize_b, vsize_a, vstart}, {22'd0, 2'b01, 2'b10, 6'h15}, "R2 retained vertical command");
        cmp({hsize_b, hsize_a, hstart}, {22'd0, 2'b10, 2'b01, 6'h3F}, "R7 horizontal setup");

        // R8
        sel(); byte_out(8'hC6); byte_out(8'h2D); desel();
        cmp({test_mode, burst_off, osc_stop, non_interlace, border_on, blink_slow, blink_on, reverse_on, display_on},
            32'b011_101101, "R8 display control fields");

        // R9
        sel(); byte_out(8'hDB); byte_out(8'h0C); desel();
        cmp({bg_phase, bg_off, int_sync, det_count}, {24'd0, 2'b10, 1'b1, 1'b1, 4'hC}, "R9 sync fields");

        // R2: reserved commands change nothing
        sel(); byte_out(8'hE5); byte_out(8'h3F); byte_out(8'hF0); byte_out(8'h00); desel();
        cmp({display_on, det_count, vstart}, {21'd0, 1'b1, 4'hC, 6'h15}, "R2 reserved commands ignored");
        cmp({31'd0, mem_we}, 32'd0, "R2 no strobe from reserved");

        // R1: partial word discarded
        sel(); send_bits(3'b101, 3); desel();
        sel(); byte_out(8'hA3); desel();
        cmp({vsize_b, vsize_a}, {28'd0, 2'b00, 2'b11}, "R1 partial word dropped");

        // R10: software reset and hold
        sel(); byte_out(8'hC1); byte_out(8'hA6); byte_out(8'h3F); desel();
        cmp({display_on, vsize_a, vsize_b, hstart, det_count}, 32'd0, "R10 fields cleared and held");
        sel(); byte_out(8'h90); byte_out(8'h22); desel();
        expect_write(0, 0, 0, 6'h22, "R10 pointer cleared");
        sel(); byte_out(8'hA6); desel();
        cmp({vsize_b, vsize_a}, {28'd0, 2'b01, 2'b10}, "R10 hold released");

        // R11: hardware reset mid-run
        sel(); byte_out(8'hC0); byte_out(8'h01); desel();
        cmp({31'd0, display_on}, 32'd1, "R8 display on");
        @(negedge clk) rst_n = 1'b0;
        tick(2);
        @(negedge clk) rst_n = 1'b1;
        tick(1);
        cmp({display_on, vsize_a, vsize_b, mem_line, mem_col, mem_code}, 32'd0, "R11 reset clears outputs");
        checks++;
        if (wq.size() != 0) begin
            fails++;
            $display("FAIL R4 unexpected writes actual=%0d expected=0", wq.size());
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule